// File: doc/BRIEF.md
# Fixed-Melody Note Sequencer

This block plays a short built-in tune. It sends a series of 5-bit note codes to a downstream tone generator, one note at a time. It reads the 8-bit switch bank every cycle. When the bank holds the song-select pattern, a three-state machine starts at the first melody entry. Each note stays on the output for a fixed number of clock cycles, set by a 2-bit duration class stored with that note. The machine then steps to the next entry. After the eleventh note it goes quiet and waits until song mode is released.

The block does not make audio and does not scan keys. Duration lengths are parameters. The defaults suit a 50 MHz clock: a quarter note is 25,000,000 cycles, a half note is 50,000,000 and a whole note is 100,000,000. One 27-bit counter times every note.

The states are `S_IDLE` (quiet, waiting for song select), `S_PLAY` (presenting a melody entry) and `S_DONE` (tune finished, quiet). The transitions are:
- `go`: `S_IDLE` to `S_PLAY` when select is seen.
- `step`: `S_PLAY` to `S_PLAY` at the end of a note that is not the last.
- `finish`: `S_PLAY` to `S_DONE` at the end of the last note.
- `abort`: `S_PLAY` to `S_IDLE` when select drops.
- `release`: `S_DONE` to `S_IDLE` when select drops.

Top module: `melody_sequencer`

## Requirements
- R1: Song mode is selected only when `sw_bank` equals 8'b00000001. For any other value the block stays quiet: `note_code` is 5'b00000 and `busy` is 0.
- R2: The melody, in order, is B A F C B A F C C E F. The codes are B=5'b11100, A=5'b11010, F=5'b10110, C=5'b10001 and E=5'b10101.
- R3: The duration classes are 2'b00 = quarter (`QUARTER_CYC`, default 25,000,000), 2'b01 = half (`HALF_CYC`, default 50,000,000) and 2'b10 = whole (`WHOLE_CYC`, default 100,000,000). The melody's classes are quarter, quarter, quarter, half, quarter, quarter, quarter, half, quarter, quarter, whole.
- R4: The first note appears in the cycle after the clock edge that samples song select. Each note then stays on the output for exactly its class's cycle count.
- R5: After the last note, `note_code` is 5'b00000 and `busy` is 0. This holds for as long as song select stays asserted.
- R6: When song select drops at any point, `note_code` is silent and `busy` is 0 from the next cycle.
- R7: Selecting song mode again after leaving it restarts the tune from its first note with the full first duration.
- R8: `busy` is 1 exactly while a melody note is being presented.
- R9: While reset is asserted, and just after it is released, `note_code` is silent and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_bank | input | 8 | Switch bank; 8'b00000001 selects song mode |
| note_code | output | 5 | Note code to the tone generator; 5'b00000 is silent |
| busy | output | 1 | High while the melody is playing |

## Verification
A wrong state register or a wrong melody index shows up at `note_code` in the very cycle it happens. It appears as a wrong code, as silence in place of a note, or as a note in place of silence. A counter or length fault moves a note boundary. The bench sees this as a miscompare at the first boundary that is off, because it compares every cycle of the tune against lengths summed from the duration classes. A fault that keeps the machine in `S_DONE` or `S_PLAY` after an abort appears either on the cycle after select drops or as a first note that is too short after re-entry.

// File: rtl/melody_pkg.sv
package melody_pkg;

    localparam int NOTE_W     = 5;
    localparam int MELODY_LEN = 11;
    localparam int IDX_W      = $clog2(MELODY_LEN);

    localparam logic [NOTE_W-1:0] NOTE_SILENT = 5'b00000;
    localparam logic [NOTE_W-1:0] NOTE_B      = 5'b11100;
    localparam logic [NOTE_W-1:0] NOTE_A      = 5'b11010;
    localparam logic [NOTE_W-1:0] NOTE_F      = 5'b10110;
    localparam logic [NOTE_W-1:0] NOTE_C      = 5'b10001;
    localparam logic [NOTE_W-1:0] NOTE_E      = 5'b10101;

    localparam logic [7:0] SONG_PATTERN = 8'b00000001;

    typedef enum logic [1:0] {
        DUR_QUARTER = 2'b00,
        DUR_HALF    = 2'b01,
        DUR_WHOLE   = 2'b10
    } dur_class_e;

    typedef struct packed {
        logic [NOTE_W-1:0] code;
        dur_class_e        dur;
    } melody_entry_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_PLAY = 2'b01,
        S_DONE = 2'b10
    } seq_state_e;

endpackage

// File: rtl/melody_rom.sv
module melody_rom
    import melody_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output melody_entry_t    entry
);

    always_comb begin
        unique case (idx)
            4'd0:    entry = '{code: NOTE_B, dur: DUR_QUARTER};
            4'd1:    entry = '{code: NOTE_A, dur: DUR_QUARTER};
            4'd2:    entry = '{code: NOTE_F, dur: DUR_QUARTER};
            4'd3:    entry = '{code: NOTE_C, dur: DUR_HALF};
            4'd4:    entry = '{code: NOTE_B, dur: DUR_QUARTER};
            4'd5:    entry = '{code: NOTE_A, dur: DUR_QUARTER};
            4'd6:    entry = '{code: NOTE_F, dur: DUR_QUARTER};
            4'd7:    entry = '{code: NOTE_C, dur: DUR_HALF};
            4'd8:    entry = '{code: NOTE_C, dur: DUR_QUARTER};
            4'd9:    entry = '{code: NOTE_E, dur: DUR_QUARTER};
            4'd10:   entry = '{code: NOTE_F, dur: DUR_WHOLE};
            default: entry = '{code: NOTE_SILENT, dur: DUR_QUARTER};
        endcase
    end

endmodule

// File: rtl/note_timer.sv
module note_timer #(
    parameter int CNT_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] last_cnt,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    assign expire = run && (cnt_q == last_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last_cnt));

    assert_idle_counter_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/melody_sequencer.sv
module melody_sequencer
    import melody_pkg::*;
#(
    parameter int CNT_W       = 27,
    parameter int QUARTER_CYC = 25_000_000,
    parameter int HALF_CYC    = 50_000_000,
    parameter int WHOLE_CYC   = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sw_bank,
    output logic [NOTE_W-1:0] note_code,
    output logic              busy
);

    localparam logic [CNT_W-1:0] Q_LAST = CNT_W'(QUARTER_CYC - 1);
    localparam logic [CNT_W-1:0] H_LAST = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] W_LAST = CNT_W'(WHOLE_CYC - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MELODY_LEN - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    melody_entry_t    cur;
    logic [CNT_W-1:0] last_cnt;
    logic             song_sel;
    logic             note_end;
    logic             playing;

    assign song_sel = (sw_bank == SONG_PATTERN);
    assign playing  = (state_q == S_PLAY);

    melody_rom u_rom (
        .idx   (idx_q),
        .entry (cur)
    );

    always_comb begin
        unique case (cur.dur)
            DUR_QUARTER: last_cnt = Q_LAST;
            DUR_HALF:    last_cnt = H_LAST;
            DUR_WHOLE:   last_cnt = W_LAST;
            default:     last_cnt = Q_LAST;
        endcase
    end

    note_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (playing),
        .last_cnt (last_cnt),
        .expire   (note_end)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_IDLE: begin
                idx_d = '0;
                if (song_sel) state_d = S_PLAY;            // go
            end
            S_PLAY: begin
                if (!song_sel) begin
                    state_d = S_IDLE;                      // abort
                    idx_d   = '0;
                end else if (note_end) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = S_DONE;                  // finish
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;              // step
                    end
                end
            end
            S_DONE: begin
                idx_d = '0;
                if (!song_sel) state_d = S_IDLE;           // release
            end
            default: begin
                state_d = S_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs
    always_comb begin
        note_code = NOTE_SILENT;
        busy      = 1'b0;
        unique case (state_q)
            S_PLAY: begin
                note_code = cur.code;
                busy      = 1'b1;
            end
            S_IDLE, S_DONE: begin
                note_code = NOTE_SILENT;
                busy      = 1'b0;
            end
            default: begin
                note_code = NOTE_SILENT;
                busy      = 1'b0;
            end
        endcase
    end

    assert_busy_has_note_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (note_code != NOTE_SILENT));

    assert_stop_on_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !song_sel |=> (!busy && note_code == NOTE_SILENT));

    assert_hold_note_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && song_sel && !note_end) |=> (busy && $stable(note_code)));

    assert_index_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && song_sel && note_end && idx_q == LAST_IDX) |=> (!busy && note_code == NOTE_SILENT));

endmodule

// File: tb/melody_sequencer_test.sv
module melody_sequencer_test;

    localparam int QC = 4;
    localparam int HC = 8;
    localparam int WC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sw_bank = 8'h00;
    logic [4:0] note_code;
    logic       busy;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    melody_sequencer #(
        .CNT_W(5), .QUARTER_CYC(QC), .HALF_CYC(HC), .WHOLE_CYC(WC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sw_bank(sw_bank),
        .note_code(note_code), .busy(busy)
    );

    function automatic logic [4:0] exp_note(input int k);
        case (k)
            0, 4:    return 5'b11100;
            1, 5:    return 5'b11010;
            2, 6:    return 5'b10110;
            3, 7, 8: return 5'b10001;
            9:       return 5'b10101;
            10:      return 5'b10110;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic int exp_len(input int k);
        if (k == 3 || k == 7) return HC;
        if (k == 10) return WC;
        return QC;
    endfunction

    function automatic logic [4:0] note_at(input int t);
        int acc = 0;
        for (int k = 0; k < 11; k++) begin
            if (t < acc + exp_len(k)) return exp_note(k);
            acc += exp_len(k);
        end
        return 5'b00000;
    endfunction

    task automatic check(input string req, input logic [4:0] act_n, input logic act_b,
                         input logic [4:0] exp_n, input logic exp_b);
        n_vec++;
        if (act_n !== exp_n || act_b !== exp_b) begin
            n_bad++;
            $display("FAIL %s t=%0t note=%b busy=%b expected note=%b busy=%b",
                     req, $time, act_n, act_b, exp_n, exp_b);
        end
    endtask

    // Advance one cycle: leave negedge, pass posedge, land on next negedge.
    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        int total;
        total = 0;
        for (int k = 0; k < 11; k++) total += exp_len(k);

        // R9: reset state
        @(negedge clk);
        check("R9", note_code, busy, 5'b00000, 1'b0);
        rst_n = 1'b1;
        tick();
        check("R9", note_code, busy, 5'b00000, 1'b0);

        // R1: sweep every switch value
        for (int v = 0; v < 256; v++) begin
            sw_bank = 8'(v);
            tick();
            if (v == 1) check("R1", note_code, busy, 5'b11100, 1'b1);
            else        check("R1", note_code, busy, 5'b00000, 1'b0);
            sw_bank = 8'h00;
            tick();
            check("R6", note_code, busy, 5'b00000, 1'b0);
        end

        // R2 R3 R4 R8: full melody, every cycle
        sw_bank = 8'h01;
        for (int t = 0; t < total; t++) begin
            tick();
            check("R2_R4", note_code, busy, note_at(t), 1'b1);
        end
        // R5: quiet after last note, select held
        for (int t = 0; t < 10; t++) begin
            tick();
            check("R5", note_code, busy, 5'b00000, 1'b0);
        end
        sw_bank = 8'h00;
        tick();
        check("R5", note_code, busy, 5'b00000, 1'b0);

        // R6 / R7: abort at many points, then restart
        for (int stop = 1; stop < total; stop += 5) begin
            sw_bank = 8'h01;
            for (int t = 0; t < stop; t++) begin
                tick();
                check("R7", note_code, busy, note_at(t), 1'b1);
            end
            sw_bank = 8'h03;
            tick();
            check("R6", note_code, busy, 5'b00000, 1'b0);
        end

        // R7: restart plays a full first note and beyond
        sw_bank = 8'h01;
        for (int t = 0; t < 2 * QC + 2; t++) begin
            tick();
            check("R7", note_code, busy, note_at(t), 1'b1);
        end
        sw_bank = 8'h00;
        tick();
        check("R6", note_code, busy, 5'b00000, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule